// File: doc/BRIEF.md
# Reversible Adder-Subtractor with Carry Control

This combinational unit is the add/subtract datapath of a 32-bit soft processor. One adder serves every operation: it forms either A + B or the reverse difference B - A (computed as B + ~A + 1). The carry-in is either a fixed value or the stored carry flag. The second operand is either a register value or a sign-extended 16-bit immediate. A four-bit operation code picks the variant. Its bit positions are fixed because the instruction decoder drives them directly.

Each variant either asks for its carry-out to be written to the flag or leaves the flag alone. The unit only raises a write-enable and never holds the flag itself. On the reverse-subtract-keep code, a separate function select turns the unit into a signed or unsigned comparator. The comparator returns the difference, with its top bit patched so that the bit is set exactly when B orders below A, even when the subtraction overflows.

Top module: `addsub_unit`

## Requirements
- R1: With op_i[0]=0 and op_i[1]=0, result_o is the low 32 bits of A + Beff and carry_o is bit 32 of that sum. Beff is the second operand chosen per R6.
- R2: With op_i[0]=0 and op_i[1]=1, result_o/carry_o are the 33-bit sum A + Beff + carry_i.
- R3: With op_i[0]=1 and op_i[1]=0, result_o/carry_o are the 33-bit sum Beff + ~A + 1 (reverse subtract).
- R4: With op_i[0]=1 and op_i[1]=1, result_o/carry_o are the 33-bit sum Beff + ~A + carry_i.
- R5: carry_we_o is 1 when op_i[2]=0 and 0 when op_i[2]=1 (keep), outside compares. The sum is the same either way.
- R6: op_i[3]=1 makes Beff the sign extension of imm_i, and rb_i has no effect. op_i[3]=0 makes Beff equal rb_i.
- R7: op_i=4'h5 with func_i=2'b01 is a signed compare. The result is Beff + ~A + 1, and when A[31] and Beff[31] differ, bit 31 is replaced by Beff[31]. Bit 31 of the result is then 1 exactly when Beff < A as signed numbers.
- R8: op_i=4'h5 with func_i=2'b11 is an unsigned compare. The result is the same difference, and when the top bits differ, bit 31 is replaced by A[31]. Bit 31 of the result is then 1 exactly when Beff < A as unsigned numbers.
- R9: Compares hold carry_we_o at 0. func_i has no effect on any op_i other than 4'h5, and func_i values 2'b00 and 2'b10 leave 4'h5 as a plain keep reverse subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand A |
| rb_i | input | 32 | Register form of the second operand |
| imm_i | input | 16 | Immediate form of the second operand, sign-extended |
| op_i | input | 4 | Bit0 reverse, bit1 carry-in from flag, bit2 keep flag, bit3 immediate |
| func_i | input | 2 | Compare select on op 4'h5: 01 signed, 11 unsigned |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Sum, difference or patched compare result |
| carry_o | output | 1 | Adder carry-out (bit 32 of the sum) |
| carry_we_o | output | 1 | Request to write carry_o into the flag |

## Verification
The hardest case to reach is a compare where the signs of the two operands differ. Only then does the patched top bit diverge from the raw difference, and random 32-bit operands reach that case without landing on the overflow edges. The stimulus therefore crosses every op and func code with the operand values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF on both sides and both carry-in values, so that every sign pairing meets every variant. Random operands follow, and a directed table pins exact sums and carries.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;
  localparam int OP_REV_BIT  = 0;
  localparam int OP_CIN_BIT  = 1;
  localparam int OP_KEEP_BIT = 2;
  localparam int OP_IMM_BIT  = 3;
  localparam int OP_W        = 4;
  localparam logic [OP_W-1:0] OP_CMP = 4'h5;

  typedef enum logic [1:0] {
    FN_NONE  = 2'b00,
    FN_CMP_S = 2'b01,
    FN_RSVD  = 2'b10,
    FN_CMP_U = 2'b11
  } fn_e;
endpackage

// File: rtl/addsub_opnd.sv
`timescale 1ns/1ps
module addsub_opnd #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] rb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] b_o
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_sext
      localparam int EXT_W = DATA_W - IMM_W;
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign b_o = use_imm_i ? imm_ext : rb_i;
endmodule

// File: rtl/addsub_core.sv
`timescale 1ns/1ps
module addsub_core #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              rev_i,
  input  logic              use_flag_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] x;
  logic              cin;
  logic [SUM_W-1:0]  full;

  always_comb begin
    x    = rev_i ? ~a_i : a_i;
    // fixed carry-in is 1 for subtract, 0 for add
    cin  = use_flag_i ? flag_i : rev_i;
    full = {1'b0, x} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin};
  end

  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];
endmodule

// File: rtl/addsub_cmpfix.sv
`timescale 1ns/1ps
module addsub_cmpfix #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] diff_i,
  input  logic              a_msb_i,
  input  logic              b_msb_i,
  input  logic              cmp_en_i,
  input  logic              unsigned_i,
  output logic [DATA_W-1:0] res_o
);
  logic patch;

  always_comb begin
    patch = cmp_en_i && (a_msb_i ^ b_msb_i);
    res_o = diff_i;
    if (patch) res_o[DATA_W-1] = unsigned_i ? a_msb_i : b_msb_i;
  end
endmodule

// File: rtl/addsub_unit.sv
`timescale 1ns/1ps
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] rb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [1:0]        func_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_we_o
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] diff;
  logic              cmp_en;
  logic              cmp_uns;

  // compare only on the reverse-keep code with a compare function
  assign cmp_en  = (op_i == OP_CMP) && (fn_e'(func_i) inside {FN_CMP_S, FN_CMP_U});
  assign cmp_uns = (fn_e'(func_i) == FN_CMP_U);

  addsub_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .rb_i      (rb_i),
    .imm_i     (imm_i),
    .use_imm_i (op_i[OP_IMM_BIT]),
    .b_o       (b_eff)
  );

  addsub_core #(.DATA_W(DATA_W)) u_core (
    .a_i        (a_i),
    .b_i        (b_eff),
    .rev_i      (op_i[OP_REV_BIT]),
    .use_flag_i (op_i[OP_CIN_BIT]),
    .flag_i     (carry_i),
    .sum_o      (diff),
    .cout_o     (carry_o)
  );

  addsub_cmpfix #(.DATA_W(DATA_W)) u_fix (
    .diff_i     (diff),
    .a_msb_i    (a_i[DATA_W-1]),
    .b_msb_i    (b_eff[DATA_W-1]),
    .cmp_en_i   (cmp_en),
    .unsigned_i (cmp_uns),
    .res_o      (result_o)
  );

  assign carry_we_o = !op_i[OP_KEEP_BIT] && !cmp_en;
endmodule

// File: rtl/addsub_chk.sv
`timescale 1ns/1ps
module addsub_chk
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] rb_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [OP_W-1:0]   op_i,
  input logic [1:0]        func_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              carry_we_o
);
  logic [DATA_W-1:0] b_ref;
  logic [DATA_W:0]   add_ref;
  logic [DATA_W:0]   rsub_ref;
  logic              is_cmp;
  logic              known;

  always_comb begin
    b_ref    = op_i[OP_IMM_BIT] ? DATA_W'($signed(imm_i)) : rb_i;
    add_ref  = {1'b0, a_i} + {1'b0, b_ref} + {{DATA_W{1'b0}}, op_i[OP_CIN_BIT] & carry_i};
    rsub_ref = {1'b0, b_ref} + {1'b0, ~a_i} + {{DATA_W{1'b0}}, 1'b1};
    is_cmp   = (op_i == OP_CMP) && func_i[0];
    known    = !$isunknown({a_i, rb_i, imm_i, op_i, func_i, carry_i});
  end

  always_comb begin
    if (known) begin
      AST_KEEP_NO_WRITE: assert (!(op_i[OP_KEEP_BIT] && carry_we_o)) else $error("keep wrote carry"); // R5
      AST_PLAIN_WRITE: assert (op_i[OP_KEEP_BIT] || carry_we_o) else $error("no carry write"); // R5
      AST_ADD_SUM: assert (op_i[OP_REV_BIT] || ({carry_o, result_o} == add_ref)) else $error("add sum"); // R1
      AST_RSUB_SUM: assert (!(op_i[OP_REV_BIT] && !op_i[OP_CIN_BIT] && !is_cmp) || ({carry_o, result_o} == rsub_ref)) else $error("rsub sum"); // R3
      AST_SCMP_ORDER: assert (!(is_cmp && !func_i[1]) || (result_o[DATA_W-1] == ($signed(b_ref) < $signed(a_i)))) else $error("signed order"); // R7
      AST_UCMP_ORDER: assert (!(is_cmp && func_i[1]) || (result_o[DATA_W-1] == (b_ref < a_i))) else $error("unsigned order"); // R8
      AST_CMP_NO_WRITE: assert (!(is_cmp && carry_we_o)) else $error("compare wrote carry"); // R9
    end
  end
endmodule

bind addsub_unit addsub_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/sim_addsub_unit.sv
`timescale 1ns/1ps
module sim_addsub_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, rb;
  logic [15:0] imm;
  logic [3:0]  op;
  logic [1:0]  func;
  logic        cin;
  logic [31:0] res;
  logic        cout, we;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addsub_unit u0 (
    .a_i(a), .rb_i(rb), .imm_i(imm), .op_i(op), .func_i(func), .carry_i(cin),
    .result_o(res), .carry_o(cout), .carry_we_o(we)
  );

  // {op, func, cin, a, rb, imm, exp_res, exp_c, exp_we}
  localparam int NV = 16;
  localparam logic [120:0] VEC [NV] = '{
    {4'h0, 2'd0, 1'b0, 32'h00000001, 32'h00000002, 16'h0000, 32'h00000003, 1'b0, 1'b1},
    {4'h0, 2'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 1'b1, 1'b1},
    {4'h1, 2'd0, 1'b0, 32'h00000001, 32'h00000005, 16'h0000, 32'h00000004, 1'b1, 1'b1},
    {4'h1, 2'd0, 1'b0, 32'h00000005, 32'h00000001, 16'h0000, 32'hFFFFFFFC, 1'b0, 1'b1},
    {4'h2, 2'd0, 1'b1, 32'h00000007, 32'h00000008, 16'h0000, 32'h00000010, 1'b0, 1'b1},
    {4'h2, 2'd0, 1'b1, 32'hFFFFFFFF, 32'h00000000, 16'h0000, 32'h00000000, 1'b1, 1'b1},
    {4'h3, 2'd0, 1'b0, 32'h00000001, 32'h00000005, 16'h0000, 32'h00000003, 1'b1, 1'b1},
    {4'h4, 2'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 1'b1, 1'b0},
    {4'h8, 2'd0, 1'b0, 32'h0000000A, 32'hDEADBEEF, 16'hFFFF, 32'h00000009, 1'b1, 1'b1},
    {4'hD, 2'd0, 1'b0, 32'h00000003, 32'hDEADBEEF, 16'h0010, 32'h0000000D, 1'b1, 1'b0},
    {4'h5, 2'd1, 1'b0, 32'h80000000, 32'h00000001, 16'h0000, 32'h00000001, 1'b0, 1'b0},
    {4'h5, 2'd3, 1'b0, 32'h80000000, 32'h00000001, 16'h0000, 32'h80000001, 1'b0, 1'b0},
    {4'h5, 2'd1, 1'b0, 32'h00000005, 32'h00000003, 16'h0000, 32'hFFFFFFFE, 1'b0, 1'b0},
    {4'h5, 2'd0, 1'b0, 32'h00000001, 32'h00000005, 16'h0000, 32'h00000004, 1'b1, 1'b0},
    {4'h1, 2'd1, 1'b0, 32'h80000000, 32'h00000001, 16'h0000, 32'h80000001, 1'b0, 1'b1},
    {4'h7, 2'd0, 1'b1, 32'h00000002, 32'h00000002, 16'h0000, 32'h00000000, 1'b1, 1'b0}
  };
  string vtag [NV] = '{"R1", "R1", "R3", "R3", "R2", "R2", "R4", "R5",
                       "R6", "R6", "R7", "R8", "R7", "R9", "R9", "R4"};

  localparam logic [31:0] CORNER [4] = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

  // reference per requirements: {we, carry, result}
  function automatic logic [33:0] ref_f(logic [3:0] o, logic [1:0] f, logic c,
                                        logic [31:0] x, logic [31:0] r, logic [15:0] i);
    logic [31:0] b = o[3] ? {{16{i[15]}}, i} : r;
    logic [32:0] s;
    logic [31:0] q;
    logic        cmp = (o == 4'h5) && (f == 2'b01 || f == 2'b11);
    if (!o[0]) s = {1'b0, x} + {1'b0, b} + {32'd0, o[1] & c};
    else       s = {1'b0, b} + {1'b0, ~x} + {32'd0, o[1] ? c : 1'b1};
    q = s[31:0];
    if (cmp && (x[31] ^ b[31])) q[31] = f[1] ? x[31] : b[31];
    return {!o[2] && !cmp, s[32], q};
  endfunction

  function automatic string tag_f(logic [3:0] o, logic [1:0] f);
    if (o == 4'h5 && f == 2'b01) return "R7";
    if (o == 4'h5 && f == 2'b11) return "R8";
    if (o[3]) return "R6";
    if (o[2]) return "R5";
    case (o[1:0])
      2'b00: return "R1";
      2'b10: return "R2";
      2'b01: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic drive(logic [3:0] o, logic [1:0] f, logic c, logic [31:0] x,
                       logic [31:0] r, logic [15:0] i);
    @(posedge clk);
    op = o; func = f; cin = c; a = x; rb = r; imm = i;
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] er, logic ec, logic ew);
    checks++;
    if (res !== er || cout !== ec || we !== ew) begin
      errors++;
      $display("FAIL %s op=%h func=%0d a=%h rb=%h imm=%h: got res=%h c=%b we=%b exp res=%h c=%b we=%b",
               tag, op, func, a, rb, imm, res, cout, we, er, ec, ew);
    end
  endtask

  initial begin
    a = '0; rb = '0; imm = '0; op = '0; func = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [120:0] v = VEC[k];
      drive(v[120:117], v[116:115], v[114], v[113:82], v[81:50], v[49:34]);
      check(vtag[k], v[33:2], v[1], v[0]);
    end

    // rb must not matter in immediate form
    drive(4'h8, 2'd0, 1'b0, 32'h5, 32'h12345678, 16'h0003);
    check("R6 rb ignored", 32'h8, 1'b0, 1'b1);
    drive(4'h8, 2'd0, 1'b0, 32'h5, 32'hFFFFFFFF, 16'h0003);
    check("R6 rb ignored", 32'h8, 1'b0, 1'b1);
    // reserved func on compare code behaves as keep reverse subtract
    drive(4'h5, 2'd2, 1'b0, 32'h80000000, 32'h1, 16'h0);
    check("R9 reserved func", 32'h80000001, 1'b0, 1'b0);

    for (int o = 0; o < 16; o++)
      for (int f = 0; f < 4; f++)
        for (int ia = 0; ia < 4; ia++)
          for (int ib = 0; ib < 4; ib++)
            for (int c = 0; c < 2; c++) begin
              logic [33:0] e;
              logic [15:0] iv = CORNER[ib][15:0];
              e = ref_f(4'(o), 2'(f), 1'(c), CORNER[ia], CORNER[ib], iv);
              drive(4'(o), 2'(f), 1'(c), CORNER[ia], CORNER[ib], iv);
              check(tag_f(4'(o), 2'(f)), e[31:0], e[32], e[33]);
            end

    for (int n = 0; n < 3000; n++) begin
      logic [33:0] e;
      logic [3:0]  ro = 4'($urandom);
      logic [1:0]  rf = 2'($urandom);
      logic        rc = 1'($urandom);
      logic [31:0] ra = $urandom;
      logic [31:0] rr = $urandom;
      logic [15:0] ri = 16'($urandom);
      if (n % 4 == 0) ro = 4'h5;
      e = ref_f(ro, rf, rc, ra, rr, ri);
      drive(ro, rf, rc, ra, rr, ri);
      check(tag_f(ro, rf), e[31:0], e[32], e[33]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule